// File: doc/BRIEF.md
# Four-Port Mailbox Interrupt Logic

This block produces the message-passing interrupts of a four-port shared memory. Every port owns one mailbox word in the four highest locations of the address space. A write from any port to a mailbox location raises the interrupt of the port that owns it. The owner acknowledges the message by reading its own mailbox location, and that read drops the interrupt.

Each port supplies a clocked address, a pair of chip enables, a read/write select and two byte-lane enables. All ports share one clock. An asynchronous active-low master reset clears every interrupt. Only the flag logic is here. The storage array and its arbitration live outside the block.

Top module: `mbox_irq`

## Requirements
- R1: While rst_ni is low, and on the first cycles after it rises, every bit of int_no is 1 (no interrupt pending).
- R2: A valid write (rw_i=0) by any port to address 7FFF, 7FFE, 7FFD or 7FFC drives int_no[0], [1], [2] or [3] low after the next rising clock edge. Port 0 owns 7FFF, port 1 owns 7FFE, port 2 owns 7FFD and port 3 owns 7FFC.
- R3: The byte-lane enables be_ni play no part in mailbox decode. A valid mailbox write with both be_ni bits at 1 still raises the owner's interrupt.
- R4: A valid read (rw_i=1) by port t of its own mailbox address returns int_no[t] to 1 after the next rising edge.
- R5: A read of a mailbox address by a port that does not own it leaves that interrupt unchanged.
- R6: If one port writes mailbox t and port t reads it in the same cycle, int_no[t] ends up low, because the set wins.
- R7: An access counts only when ce0_ni=0 and ce1_i=1 on that port. With either enable inactive, the access changes no interrupt.
- R8: Writes and reads to any address below 7FFC change no interrupt.
- R9: An interrupt holds its value in every cycle with no qualifying set or clear.
- R10: Driving rst_ni low sets all int_no bits to 1 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock, rising edge |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| ce0_ni | input | NUM_PORTS | Per-port chip enable, active low |
| ce1_i | input | NUM_PORTS | Per-port chip enable, active high |
| rw_i | input | NUM_PORTS | Per-port access kind: 1 read, 0 write |
| addr_i | input | NUM_PORTS x ADDR_W | Per-port word address |
| be_ni | input | NUM_PORTS x 2 | Per-port byte-lane enables, active low (not used in decode) |
| int_no | output | NUM_PORTS | Per-port mailbox interrupt, active low |

## Verification
The assertions assume that rw_i, addr_i and both chip enables are known and settled at each rising edge while reset is released, because a set or clear is judged from those values alone. They also assume one shared clock, so every port's access belongs to one common edge. The bench meets both assumptions by changing every input only on falling edges and by giving idle ports defined values. Idle ports carry a mailbox address with a chip enable inactive, so the stimulus also tests the chip-enable gating.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  typedef enum logic {
    ACC_WR = 1'b0,
    ACC_RD = 1'b1
  } acc_e;

  function automatic logic acc_ok(input logic ce_n, input logic ce);
    return !ce_n && ce;
  endfunction
endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned PORT_IDX  = 0
) (
  input  logic                 ce0_ni,
  input  logic                 ce1_i,
  input  logic                 rw_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_PORTS-1:0] wr_hit_o,
  output logic                 rd_own_o
);
  import mbox_irq_pkg::*;

  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic                 live;
  logic [NUM_PORTS-1:0] match;

  assign live = acc_ok(ce0_ni, ce1_i);

  for (genvar t = 0; t < NUM_PORTS; t++) begin : g_match
    localparam logic [ADDR_W-1:0] MBOX = TOP_ADDR - ADDR_W'(t);
    assign match[t]    = (addr_i == MBOX);
    assign wr_hit_o[t] = live && (acc_e'(rw_i) == ACC_WR) && match[t];
  end

  assign rd_own_o = live && (acc_e'(rw_i) == ACC_RD) && match[PORT_IDX];
endmodule

// File: rtl/mbox_set_merge.sv
module mbox_set_merge #(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] wr_hit_i,  // [source][target]
  output logic [NUM_PORTS-1:0]                set_o
);
  for (genvar t = 0; t < NUM_PORTS; t++) begin : g_tgt
    logic [NUM_PORTS-1:0] col;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_src
      assign col[p] = wr_hit_i[p][t];
    end
    assign set_o[t] = |col;
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic int_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    int_no <= 1'b1;
    else if (set_i) int_no <= 1'b0;  // set has priority
    else if (clr_i) int_no <= 1'b1;
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 15
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              ce0_ni,
  input  logic [NUM_PORTS-1:0]              ce1_i,
  input  logic [NUM_PORTS-1:0]              rw_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_i,
  input  logic [NUM_PORTS-1:0][1:0]         be_ni,
  output logic [NUM_PORTS-1:0]              int_no
);
  localparam int unsigned MIN_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  if (ADDR_W < MIN_W) begin : g_bad_cfg
    initial $error("ADDR_W too small for NUM_PORTS");
  end

  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] wr_hit;
  logic [NUM_PORTS-1:0]                rd_own;
  logic [NUM_PORTS-1:0]                set;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mbox_port_dec #(
      .NUM_PORTS(NUM_PORTS),
      .ADDR_W   (ADDR_W),
      .PORT_IDX (p)
    ) u_dec (
      .ce0_ni  (ce0_ni[p]),
      .ce1_i   (ce1_i[p]),
      .rw_i    (rw_i[p]),
      .addr_i  (addr_i[p]),
      .wr_hit_o(wr_hit[p]),
      .rd_own_o(rd_own[p])
    );
  end

  mbox_set_merge #(.NUM_PORTS(NUM_PORTS)) u_merge (
    .wr_hit_i(wr_hit),
    .set_o   (set)
  );

  for (genvar t = 0; t < NUM_PORTS; t++) begin : g_flag
    mbox_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set[t]),
      .clr_i (rd_own[t]),
      .int_no(int_no[t])
    );
  end
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 15
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [NUM_PORTS-1:0]              ce0_ni,
  input logic [NUM_PORTS-1:0]              ce1_i,
  input logic [NUM_PORTS-1:0]              rw_i,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_i,
  input logic [NUM_PORTS-1:0][1:0]         be_ni,
  input logic [NUM_PORTS-1:0]              int_no
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic [NUM_PORTS-1:0] en;
  logic [NUM_PORTS-1:0] any_wr;
  logic [NUM_PORTS-1:0] own_rd;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) en[p] = (ce0_ni[p] == 1'b0) && (ce1_i[p] == 1'b1);
    for (int t = 0; t < NUM_PORTS; t++) begin
      any_wr[t] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++)
        if (en[p] && !rw_i[p] && addr_i[p] == TOP_ADDR - ADDR_W'(t)) any_wr[t] = 1'b1;
      own_rd[t] = en[t] && rw_i[t] && addr_i[t] == TOP_ADDR - ADDR_W'(t);
    end
  end

  // R1 R10
  always @(negedge clk_i) begin
    if (!rst_ni) reset_idle_chk: assert (int_no == '1);
  end

  for (genvar t = 0; t < NUM_PORTS; t++) begin : g_t
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
      // R2
      write_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en[p] && !rw_i[p] && addr_i[p] == TOP_ADDR - ADDR_W'(t)) |=> !int_no[t]);
      // R3
      lanes_off_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en[p] && !rw_i[p] && be_ni[p] == 2'b11 && addr_i[p] == TOP_ADDR - ADDR_W'(t))
        |=> !int_no[t]);
    end
    // R4
    own_read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_rd[t] && !any_wr[t]) |=> int_no[t]);
    // R9 (also covers R5 R7 R8)
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!own_rd[t] && !any_wr[t]) |=> $stable(int_no[t]));
  end
endmodule

bind mbox_irq mbox_irq_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbox_irq_bench.sv
module mbox_irq_bench;
  localparam int unsigned NP = 4;
  localparam int unsigned AW = 15;

  typedef struct packed {
    logic [3:0]       en;     // 1: ce0_ni=0, ce1_i=1
    logic [3:0]       rd;     // 1: read, 0: write
    logic [3:0][14:0] addr;   // {a3,a2,a1,a0}
    logic [3:0]       exp_n;  // expected int_no
    int unsigned      req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'b0010, 4'b0000, {15'h7FFF, 15'h7FFF, 15'h7FFF, 15'h7FFF}, 4'b1110, 2},  // R2 p1->mbox0
    '{4'b0001, 4'b0000, {15'h7FFF, 15'h7FFF, 15'h7FFF, 15'h7FFE}, 4'b1100, 2},  // R2 p0->mbox1
    '{4'b1000, 4'b0000, {15'h7FFD, 15'h7FFF, 15'h7FFF, 15'h7FFF}, 4'b1000, 2},  // R2 p3->mbox2
    '{4'b0100, 4'b0000, {15'h7FFF, 15'h7FFC, 15'h7FFF, 15'h7FFF}, 4'b0000, 2},  // R2 p2->mbox3
    '{4'b0010, 4'b0010, {15'h7FFF, 15'h7FFF, 15'h7FFF, 15'h7FFF}, 4'b0000, 5},  // R5 p1 reads mbox0
    '{4'b0001, 4'b0001, {15'h7FFF, 15'h7FFF, 15'h7FFF, 15'h7FFF}, 4'b0001, 4},  // R4 p0 clears
    '{4'b0000, 4'b0000, {15'h7FFF, 15'h7FFF, 15'h7FFF, 15'h7FFF}, 4'b0001, 9},  // R9 disabled writes
    '{4'b0010, 4'b0010, {15'h7FFF, 15'h7FFF, 15'h7FFC, 15'h7FFF}, 4'b0001, 5},  // R5 p1 reads mbox3
    '{4'b0010, 4'b0010, {15'h7FFF, 15'h7FFF, 15'h7FFE, 15'h7FFF}, 4'b0011, 4},  // R4 p1 clears
    '{4'b1100, 4'b1100, {15'h7FFC, 15'h7FFD, 15'h7FFF, 15'h7FFF}, 4'b1111, 4},  // R4 p2,p3 clear
    '{4'b1100, 4'b0000, {15'h0000, 15'h7FFB, 15'h7FFF, 15'h7FFF}, 4'b1111, 8},  // R8 non-mailbox
    '{4'b1100, 4'b1000, {15'h7FFC, 15'h7FFC, 15'h7FFF, 15'h7FFF}, 4'b0111, 6},  // R6 set beats clear
    '{4'b1000, 4'b1000, {15'h7FFC, 15'h7FFF, 15'h7FFF, 15'h7FFF}, 4'b1111, 4}   // R4 p3 clears
  };

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic [NP-1:0]             ce0_n, ce1, rw;
  logic [NP-1:0][AW-1:0]     addr;
  logic [NP-1:0][1:0]        be_n;
  logic [NP-1:0]             int_n;
  int                        checks = 0;
  int                        fails  = 0;
  bit                        done   = 1'b0;

  always #5 clk = ~clk;

  mbox_irq #(.NUM_PORTS(NP), .ADDR_W(AW)) u_mbox_irq (
    .clk_i (clk),
    .rst_ni(rst_n),
    .ce0_ni(ce0_n),
    .ce1_i (ce1),
    .rw_i  (rw),
    .addr_i(addr),
    .be_ni (be_n),
    .int_no(int_n)
  );

  task automatic check(input string req, input logic [NP-1:0] exp);
    checks++;
    if (int_n !== exp) begin
      fails++;
      $display("FAIL %s int_no=%b expected=%b", req, int_n, exp);
    end
  endtask

  task automatic idle();
    ce0_n = '1; ce1 = '1; rw = '0; be_n = '0;
    for (int p = 0; p < NP; p++) addr[p] = 15'h7FFF;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check("R1", 4'b1111);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 4'b1111);

    for (int i = 0; i < NV; i++) begin
      for (int p = 0; p < NP; p++) begin
        ce0_n[p] = !VECS[i].en[p];
        rw[p]    = VECS[i].rd[p];
        addr[p]  = VECS[i].addr[p];
      end
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp_n);
    end
    idle(); @(negedge clk);

    // R3: lanes disabled, p2 writes mbox2
    ce0_n[2] = 1'b0; rw[2] = 1'b0; addr[2] = 15'h7FFD; be_n[2] = 2'b11;
    @(negedge clk); check("R3", 4'b1011);
    idle(); ce0_n[2] = 1'b0; rw[2] = 1'b1; addr[2] = 15'h7FFD;
    @(negedge clk); check("R4", 4'b1111);

    // R7: each enable inactive in turn
    idle(); ce0_n[0] = 1'b0; ce1[0] = 1'b0; addr[0] = 15'h7FFE;
    @(negedge clk); check("R7 ce1", 4'b1111);
    idle(); ce0_n[0] = 1'b1; ce1[0] = 1'b1; addr[0] = 15'h7FFE;
    @(negedge clk); check("R7 ce0", 4'b1111);

    // R9: hold over idle cycles
    idle(); ce0_n[1] = 1'b0; addr[1] = 15'h7FFC;
    @(negedge clk); check("R2", 4'b0111);
    idle(); repeat (3) @(negedge clk); check("R9", 4'b0111);

    // R10: asynchronous clear
    #2 rst_n = 1'b0;
    #1 check("R10", 4'b1111);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R1", 4'b1111);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule